// File: doc/BRIEF.md
# Cache Way Configuration Registers

This block is the small register file that sits beside a set-associative cache and decides, way by way, how the data array is used. Software reaches it over a flat register port with one request per cycle and one response in the following cycle. Through that port it chooses which ways act as scratchpad memory and which act as cache. It can also ask for ways to be flushed and switch a global bypass on or off. The block also shows software the outcome of the tag-memory self-test that runs after every reset.

Every per-way register uses the same bit layout: bit i always stands for way i. The number of ways therefore cannot exceed the data width of the register port. The self-test reports completion through a level input together with a per-way error mask. On the cycle it completes, the hardware takes over the way-mode register. Ways that passed become cache, ways that failed stay scratchpad, and any value software wrote earlier is lost. Flush requests are held on a per-way request bus until the flush engine acknowledges them, and then they clear by themselves.

Top module: `cache_way_cfg`

## Requirements
- R1: After reset, spm_mode_o is all ones (every way scratchpad), flush_req_o is zero, bypass_o is 0, rsp_valid_o is 0, and the self-test result and done flag read as zero.
- R2: The word index is the byte address divided by DATA_W/8. Index 0 is way mode, 1 is flush request, 2 is bypass, 3 is self-test result and 4 is self-test status. Every request cycle is answered by exactly one response in the next cycle, and there is no response without a request.
- R3: A write to way mode sets spm_mode_o from wdata bits [NUM_WAYS-1:0] in the next cycle, where a 1 means scratchpad and a 0 means cache. Higher bits are dropped and read back as zero.
- R4: Writing the flush register ORs the ones in wdata into flush_req_o, and zeros have no effect. A request bit stays set until the same bit of flush_ack_i is high, and then it clears in the next cycle.
- R5: bypass_o follows bit 0 of the last write to the bypass register. The register reads back as that bit.
- R6: On the first cycle in which bist_done_i is high after reset, spm_mode_o becomes bist_err_i in the next cycle. This replaces any earlier write and beats a write to way mode in the same cycle.
- R7: At that completion the result register captures bist_err_i. The status register then reads 1 in bit 0 and zero elsewhere, and stays so until reset.
- R8: Writes to the result and status registers get an OKAY response and change nothing.
- R9: A request whose word index is 5 or more gets an error response with zero read data, and changes no state. Mapped requests get OKAY, and responses to writes carry zero data.
- R10: Once completion has happened, later writes to way mode take effect as in R3. A bist_done_i that stays high never applies the override again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Register request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response for last cycle's request |
| rsp_err_o | output | 1 | Error response (unmapped address) |
| rsp_rdata_o | output | DATA_W | Read data |
| bist_done_i | input | 1 | Self-test finished (level) |
| bist_err_i | input | NUM_WAYS | Per-way failure mask, valid with bist_done_i |
| spm_mode_o | output | NUM_WAYS | Per-way mode, 1 = scratchpad |
| bypass_o | output | 1 | Send all traffic around the cache |
| flush_req_o | output | NUM_WAYS | Pending per-way flush requests |
| flush_ack_i | input | NUM_WAYS | Per-way flush acknowledge |

## Verification
The assertions assume that bist_err_i is stable and meaningful on the cycle in which bist_done_i first rises, and that bist_done_i is low while reset is active. Without those, the completion override and the sticky done flag have no defined reference. The stimulus holds bist_done_i low through reset and sets the failure mask on the same edge that raises it. It keeps the mask unchanged after that. Flush acknowledges are given only for ways that have a request pending, and each lasts one cycle. The request inputs change only between clock edges.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

    // Word indices of the register map; the writable ones come first.
    typedef enum logic [2:0] {
        REG_MODE   = 3'd0,
        REG_FLUSH  = 3'd1,
        REG_BYPASS = 3'd2,
        REG_RESULT = 3'd3,
        REG_STATUS = 3'd4
    } reg_idx_e;

    localparam int unsigned NUM_REGS = 5;
    localparam int unsigned NUM_RW   = 3;

endpackage

// File: rtl/cwc_decode.sv
module cwc_decode
    import cwc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                hit_o,
    output logic [NUM_REGS-1:0] sel_o
);

    localparam int unsigned BYTE_OFFS = $clog2(DATA_W / 8);

    logic [ADDR_W-1:0] word;

    assign word  = addr_i >> BYTE_OFFS;
    assign hit_o = (word < ADDR_W'(NUM_REGS));

    // One select line per register.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel_o[g] = (word == ADDR_W'(g));
    end

endmodule

// File: rtl/cwc_state.sv
module cwc_state
    import cwc_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [NUM_REGS-1:0] sel_i,
    input  logic [NUM_WAYS-1:0] wdata_i,
    input  logic                bist_done_i,
    input  logic [NUM_WAYS-1:0] bist_err_i,
    input  logic [NUM_WAYS-1:0] flush_ack_i,
    output logic [NUM_WAYS-1:0] spm_o,
    output logic [NUM_WAYS-1:0] flush_o,
    output logic                bypass_o,
    output logic [NUM_WAYS-1:0] result_o,
    output logic                done_o
);

    typedef struct packed {
        logic [NUM_WAYS-1:0] spm;
        logic [NUM_WAYS-1:0] flush;
        logic                bypass;
        logic [NUM_WAYS-1:0] result;
        logic                done;
    } state_t;

    state_t st_d, st_q;
    logic   bist_rise;
    logic   wr_mode, wr_flush, wr_bypass;

    assign bist_rise = bist_done_i && !st_q.done;
    assign wr_mode   = wr_en_i && sel_i[REG_MODE];
    assign wr_flush  = wr_en_i && sel_i[REG_FLUSH];
    assign wr_bypass = wr_en_i && sel_i[REG_BYPASS];

    always_comb begin
        st_d = st_q;
        if (wr_mode) begin
            st_d.spm = wdata_i;
        end
        if (wr_bypass) begin
            st_d.bypass = wdata_i[0];
        end
        st_d.flush = (st_q.flush | (wr_flush ? wdata_i : '0)) & ~flush_ack_i;
        // Completion of the self-test takes priority over software.
        if (bist_rise) begin
            st_d.spm    = bist_err_i;
            st_d.result = bist_err_i;
            st_d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.spm    <= '1;
            st_q.flush  <= '0;
            st_q.bypass <= 1'b0;
            st_q.result <= '0;
            st_q.done   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign spm_o    = st_q.spm;
    assign flush_o  = st_q.flush;
    assign bypass_o = st_q.bypass;
    assign result_o = st_q.result;
    assign done_o   = st_q.done;

    AST_FLUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((($past(st_q.flush) & ~$past(flush_ack_i)) & ~st_q.flush) == '0)); // R4
    AST_FLUSH_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.flush & $past(flush_ack_i)) == '0)); // R4
    AST_BIST_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bist_done_i && !st_q.done) |=> (st_q.spm == $past(bist_err_i))); // R6
    AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.done |=> st_q.done); // R7
    AST_DONE_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.done && !bist_done_i) |=> !st_q.done); // R7
    AST_RESULT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.done |=> $stable(st_q.result)); // R8
    AST_MODE_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.done && !(wr_en_i && sel_i[REG_MODE])) |=> $stable(st_q.spm)); // R10

endmodule

// File: rtl/cwc_resp.sv
module cwc_resp
    import cwc_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_WAYS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic                hit_i,
    input  logic [NUM_REGS-1:0] sel_i,
    input  logic [NUM_WAYS-1:0] spm_i,
    input  logic [NUM_WAYS-1:0] flush_i,
    input  logic                bypass_i,
    input  logic [NUM_WAYS-1:0] result_i,
    input  logic                done_i,
    output logic                rsp_valid_o,
    output logic                rsp_err_o,
    output logic [DATA_W-1:0]   rsp_rdata_o
);

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t        rsp_d, rsp_q;
    logic [DATA_W-1:0] mux;

    always_comb begin
        mux = '0;
        if (sel_i[REG_MODE])   mux = DATA_W'(spm_i);
        if (sel_i[REG_FLUSH])  mux = DATA_W'(flush_i);
        if (sel_i[REG_BYPASS]) mux = DATA_W'(bypass_i);
        if (sel_i[REG_RESULT]) mux = DATA_W'(result_i);
        if (sel_i[REG_STATUS]) mux = DATA_W'(done_i);
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid_i;
        rsp_d.err   = req_valid_i && !hit_i;
        if (req_valid_i && hit_i && !req_write_i) begin
            rsp_d.rdata = mux;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_err_o   = rsp_q.err;
    assign rsp_rdata_o = rsp_q.rdata;

    AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o); // R2
    AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o); // R2
    AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == '0)); // R9
    AST_MAPPED_OKAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && hit_i) |=> !rsp_err_o); // R9

endmodule

// File: rtl/cache_way_cfg.sv
module cache_way_cfg
    import cwc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_WAYS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [DATA_W-1:0]   req_wdata_i,
    output logic                rsp_valid_o,
    output logic                rsp_err_o,
    output logic [DATA_W-1:0]   rsp_rdata_o,
    input  logic                bist_done_i,
    input  logic [NUM_WAYS-1:0] bist_err_i,
    output logic [NUM_WAYS-1:0] spm_mode_o,
    output logic                bypass_o,
    output logic [NUM_WAYS-1:0] flush_req_o,
    input  logic [NUM_WAYS-1:0] flush_ack_i
);

    logic                hit;
    logic [NUM_REGS-1:0] sel;
    logic                wr_en;
    logic [NUM_WAYS-1:0] result;
    logic                done;
    logic                unused_wdata;

    assign wr_en        = req_valid_i && req_write_i && hit;
    assign unused_wdata = ^req_wdata_i;

    cwc_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .addr_i (req_addr_i),
        .hit_o  (hit),
        .sel_o  (sel)
    );

    cwc_state #(
        .NUM_WAYS (NUM_WAYS)
    ) u_state (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en),
        .sel_i       (sel),
        .wdata_i     (req_wdata_i[NUM_WAYS-1:0]),
        .bist_done_i (bist_done_i),
        .bist_err_i  (bist_err_i),
        .flush_ack_i (flush_ack_i),
        .spm_o       (spm_mode_o),
        .flush_o     (flush_req_o),
        .bypass_o    (bypass_o),
        .result_o    (result),
        .done_o      (done)
    );

    cwc_resp #(
        .DATA_W   (DATA_W),
        .NUM_WAYS (NUM_WAYS)
    ) u_resp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .hit_i       (hit),
        .sel_i       (sel),
        .spm_i       (spm_mode_o),
        .flush_i     (flush_req_o),
        .bypass_i    (bypass_o),
        .result_i    (result),
        .done_i      (done),
        .rsp_valid_o (rsp_valid_o),
        .rsp_err_o   (rsp_err_o),
        .rsp_rdata_o (rsp_rdata_o)
    );

endmodule

// File: tb/cache_way_cfg_test.sv
module cache_way_cfg_test;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          bist_done = 1'b0;
    logic [NW-1:0] bist_err = '0;
    logic [NW-1:0] spm_mode, flush_req, flush_ack = '0;
    logic          bypass;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    live     = 0;
    bit    ended    = 0;
    string cur_req  = "R1";

    always #5 clk = ~clk;

    cache_way_cfg #(.ADDR_W(AW), .DATA_W(DW), .NUM_WAYS(NW)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
        .bist_done_i(bist_done), .bist_err_i(bist_err),
        .spm_mode_o(spm_mode), .bypass_o(bypass),
        .flush_req_o(flush_req), .flush_ack_i(flush_ack)
    );

    // Behavioural reference model
    logic [NW-1:0] m_spm, m_flush, m_res;
    logic          m_byp, m_done;
    logic          e_valid, e_err;
    logic [DW-1:0] e_data;

    always @(posedge clk) begin : model
        int            word;
        logic [NW-1:0] spm_n, flush_n;
        if (!rst_n) begin
            m_spm <= '1; m_flush <= '0; m_res <= '0; m_byp <= 0; m_done <= 0;
            e_valid <= 0; e_err <= 0; e_data <= '0;
        end else begin
            word = int'(req_addr) / (DW / 8);
            spm_n = m_spm;
            flush_n = m_flush;
            e_valid <= req_valid;
            e_err   <= req_valid && word >= 5;
            e_data  <= '0;
            if (req_valid && !req_write && word < 5) begin
                case (word)
                    0: e_data <= DW'(m_spm);
                    1: e_data <= DW'(m_flush);
                    2: e_data <= DW'(m_byp);
                    3: e_data <= DW'(m_res);
                    default: e_data <= DW'(m_done);
                endcase
            end
            if (req_valid && req_write) begin
                if (word == 0) spm_n = req_wdata[NW-1:0];
                if (word == 1) flush_n = flush_n | req_wdata[NW-1:0];
                if (word == 2) m_byp <= req_wdata[0];
            end
            flush_n = flush_n & ~flush_ack;
            if (bist_done && !m_done) begin
                spm_n = bist_err;
                m_res <= bist_err;
                m_done <= 1;
            end
            m_spm <= spm_n;
            m_flush <= flush_n;
        end
    end

    task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk({cur_req, " R2 rsp_valid"}, DW'(rsp_valid), DW'(e_valid));
            if (e_valid) begin
                chk({cur_req, " R9 rsp_err"}, DW'(rsp_err), DW'(e_err));
                chk({cur_req, " rdata"}, rsp_rdata, e_data);
            end
            chk({cur_req, " spm_mode"}, DW'(spm_mode), DW'(m_spm));
            chk({cur_req, " flush_req"}, DW'(flush_req), DW'(m_flush));
            chk({cur_req, " bypass"}, DW'(bypass), DW'(m_byp));
        end
    end

    task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd_chk(string tag, logic [AW-1:0] a, logic [DW-1:0] exp, bit exp_err);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        chk({tag, " read data"}, rsp_rdata, exp);
        chk({tag, " read err"}, DW'(rsp_err), DW'(exp_err));
        req_valid = 0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1;
        live = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 spm reset", DW'(spm_mode), 32'hFF);
        chk("R1 flush reset", DW'(flush_req), 32'h0);
        chk("R1 bypass reset", DW'(bypass), 32'h0);
        chk("R1 rsp idle", DW'(rsp_valid), 32'h0);
        rd_chk("R1 result", 8'd12, 32'h0, 0);
        rd_chk("R1 status", 8'd16, 32'h0, 0);

        cur_req = "R3";
        access(1, 8'd0, 32'hFFFF_FFA5);
        rd_chk("R3 mode readback", 8'd0, 32'h0000_00A5, 0);
        chk("R3 mode pins", DW'(spm_mode), 32'hA5);

        cur_req = "R5";
        access(1, 8'd8, 32'h0000_0003);
        chk("R5 bypass set", DW'(bypass), 32'h1);
        rd_chk("R5 bypass readback", 8'd8, 32'h1, 0);
        access(1, 8'd8, 32'h0000_0002);
        chk("R5 bypass clear", DW'(bypass), 32'h0);

        cur_req = "R4";
        access(1, 8'd4, 32'h0F);
        access(1, 8'd4, 32'h30);
        chk("R4 flush accumulate", DW'(flush_req), 32'h3F);
        repeat (3) @(negedge clk);
        chk("R4 flush held", DW'(flush_req), 32'h3F);
        flush_ack = 8'h01;
        @(negedge clk);
        flush_ack = 8'h00;
        chk("R4 flush ack", DW'(flush_req), 32'h3E);
        rd_chk("R4 flush readback", 8'd4, 32'h3E, 0);

        cur_req = "R8";
        access(1, 8'd12, 32'hFFFF_FFFF);
        access(1, 8'd16, 32'hFFFF_FFFF);
        rd_chk("R8 result unchanged", 8'd12, 32'h0, 0);
        rd_chk("R8 status unchanged", 8'd16, 32'h0, 0);

        cur_req = "R9";
        rd_chk("R9 unmapped read", 8'd20, 32'h0, 1);
        access(1, 8'h40, 32'h0);
        chk("R9 unmapped write no effect", DW'(spm_mode), 32'hA5);

        cur_req = "R6";
        access(1, 8'd0, 32'h11);
        chk("R6 pre-test write", DW'(spm_mode), 32'h11);
        @(negedge clk);
        bist_done = 1; bist_err = 8'h24;
        req_valid = 1; req_write = 1; req_addr = 8'd0; req_wdata = 32'h77;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk("R6 override wins", DW'(spm_mode), 32'h24);
        cur_req = "R7";
        rd_chk("R7 result captured", 8'd12, 32'h24, 0);
        rd_chk("R7 status done", 8'd16, 32'h1, 0);

        cur_req = "R10";
        access(1, 8'd0, 32'h0F);
        repeat (4) @(negedge clk);
        chk("R10 post-test write holds", DW'(spm_mode), 32'h0F);
        rd_chk("R10 mode readback", 8'd0, 32'h0F, 0);
        rd_chk("R7 status still done", 8'd16, 32'h1, 0);

        cur_req = "R2";
        access(0, 8'd0, 32'h0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule